// File: doc/BRIEF.md
# Periodic Tick Timer with Register Access

This block is a down-counting periodic timer that sits behind a small 32-bit register port. Software loads a reload value, selects whether the counter advances on every core clock or only on cycles where an external reference strobe is high, and enables counting. Each time the counter steps from one to zero, the block raises a sticky count flag and, if interrupts are enabled, emits a one-cycle interrupt pulse. On the next qualified tick the counter restarts from the reload value, which gives a fixed-period event source.

The register port is a single-cycle request with a valid strobe, a write flag, a byte address, write data and a privilege attribute. Read data and the error response are combinational in the request cycle. Write side effects, and the read side effect of clearing the flag, take effect at the clock edge that ends the request. A fixed calibration word is built from parameters. It reports whether a reference strobe exists, the number of reference ticks in ten milliseconds minus one, and whether that count is inexact.

Top module: `ptick_timer`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control), 0x4 (reload), 0x8 (current count) and 0xC (calibration). A read of any other offset returns zero, and a write to any other offset changes no state.
- R2: The control word holds enable at bit 0, interrupt enable at bit 1, clock source at bit 2 (1 = core clock, 0 = reference strobe) and the count flag at bit 16. A control write stores only bits 2:0.
- R3: A privileged control read returns the count flag as it stands, and the flag is cleared at the end of that read cycle. A flag being set in the same cycle takes priority.
- R4: A reload write keeps only data bits 23:0. The reload register reads back with bits 31:24 at zero.
- R5: When the counter steps from 1 to 0, the count flag is set. If interrupt enable is 1, the interrupt output is high for exactly one cycle. The next qualified tick at zero loads the reload value.
- R6: If the counter reaches zero while the reload value is zero, counting halts and the enable bit stays set. A later reload write does not restart it.
- R7: A privileged write of any data to offset 0x8 sets the counter to zero and clears the count flag. The next tick loads the reload value, or, with a zero reload, counting stays halted. This write overrides a tick in the same cycle.
- R8: A request with the user attribute gets the error response and read data zero, and it changes no register, counter or flag.
- R9: With the no-reference parameter set, the clock-source bit reads 1 after reset and stays 1 whatever is written to it.
- R10: Calibration reads as bit 31 no-reference, bit 30 skew and bits 23:0 the ten-millisecond count minus one. Without a reference, it reads 0x80000000.
- R11: After reset, control reads 0 (or 0x4 without a reference), reload and count read 0, and no counting happens.
- R12: A control write that changes enable from 0 to 1 starts counting from the present count. A write that changes it to 0 freezes the count. A write that keeps enable at 1 leaves counting as it was, whether running or halted.
- R13: The counter advances only on a tick: every cycle when clock source is 1, or only on cycles where the reference strobe is high when it is 0. A clock-source change applies from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick strobe, already synchronous to clk |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | 1 = unprivileged request |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the request cycle |
| rsp_err | output | 1 | Error response for unprivileged requests |
| irq_pulse | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The embedded properties check the following on every cycle: the interrupt is a single-cycle pulse and is always accompanied by the count flag; unprivileged requests always error with zero data; a current-value write zeroes the count; a zero reload halts counting at expiry; the count never moves without a tick; a control read clears the flag; and the forced clock-source bit stays high. Only the bench scenarios can show the cycle-exact period against a controlled reference strobe, the exact register read-back encodings including calibration, the priority of a count clear over a same-cycle tick, and that a halted counter ignores later reload and same-value enable writes.

// File: rtl/ptick_pkg.sv
package ptick_pkg;

   localparam int BUS_W = 32;

   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_IE_BIT   = 1;
   localparam int CTRL_CS_BIT   = 2;
   localparam int CTRL_FLAG_BIT = 16;

   localparam int CAL_NOREF_BIT = 31;
   localparam int CAL_SKEW_BIT  = 30;

   localparam logic [7:0] OFF_CTRL   = 8'h00;
   localparam logic [7:0] OFF_RELOAD = 8'h04;
   localparam logic [7:0] OFF_COUNT  = 8'h08;
   localparam logic [7:0] OFF_CALIB  = 8'h0C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_RELOAD,
      SEL_COUNT,
      SEL_CALIB
   } reg_sel_e;

   typedef struct packed {
      logic cs;
      logic ie;
      logic en;
   } ctrl_t;

endpackage

// File: rtl/ptick_qual.sv
module ptick_qual #(
   parameter bit HAS_REF = 1'b1
) (
   input  logic clksrc,
   input  logic ref_tick,
   output logic qual
);

   generate
      if (HAS_REF) begin : g_ref
         assign qual = clksrc | ref_tick;
      end else begin : g_noref
         logic unused_inputs;
         assign unused_inputs = clksrc ^ ref_tick;
         assign qual = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/ptick_calib.sv
module ptick_calib
   import ptick_pkg::*;
#(
   parameter int CNT_W      = 24,
   parameter bit HAS_REF    = 1'b1,
   parameter int TENMS_CNT  = 1000,
   parameter bit TENMS_SKEW = 1'b0
) (
   output logic [BUS_W-1:0] calib
);

   generate
      if (CNT_W < 2 || CNT_W > CAL_SKEW_BIT) begin : g_bad_width
         $error("ptick_calib: CNT_W out of range");
      end
      if (HAS_REF) begin : g_ref
         if (TENMS_CNT < 1 || TENMS_CNT > (2 ** CNT_W)) begin : g_bad_cnt
            $error("ptick_calib: TENMS_CNT does not fit the counter");
         end
         localparam logic [CNT_W-1:0] FIELD = CNT_W'(TENMS_CNT - 1);
         always_comb begin
            calib = '0;
            calib[CNT_W-1:0]   = FIELD;
            calib[CAL_SKEW_BIT] = TENMS_SKEW;
         end
      end else begin : g_noref
         always_comb begin
            calib = '0;
            calib[CAL_NOREF_BIT] = 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/ptick_counter.sv
module ptick_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             qual,
   input  logic             start,
   input  logic             stop,
   input  logic             clear,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             expire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic step;
   logic at_one;
   logic at_zero;
   logic reload_zero;

   assign step        = enable & running & qual;
   assign at_one      = (count == ONE);
   assign at_zero     = (count == '0);
   assign reload_zero = (reload == '0);
   assign expire      = step & ~clear & at_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count   <= '0;
         running <= 1'b0;
      end else begin
         if (stop) begin
            running <= 1'b0;
         end else if (start) begin
            running <= 1'b1;
         end
         if (clear) begin
            count <= '0;
            if (reload_zero) begin
               running <= 1'b0;
            end
         end else if (step) begin
            if (at_zero) begin
               if (reload_zero) begin
                  running <= 1'b0;
               end else begin
                  count <= reload;
               end
            end else begin
               count <= count - ONE;
               if (at_one && reload_zero) begin
                  running <= 1'b0;
               end
            end
         end
      end
   end

   // R7
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

   // R6
   zero_reload_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && at_one && reload_zero && !start) |=> !running);

   // R12
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> $stable(count));

   // R5
   expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear && at_zero && !reload_zero) |=> (count == $past(reload)));

endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
   import ptick_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int CNT_W      = 24,
   parameter bit HAS_REF    = 1'b1,
   parameter int TENMS_CNT  = 1000,
   parameter bit TENMS_SKEW = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_user,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BUS_W-1:0]  req_wdata,
   output logic [BUS_W-1:0]  rsp_rdata,
   output logic              rsp_err,
   output logic              irq_pulse
);

   localparam logic CS_FORCE = (HAS_REF == 1'b0);

   generate
      if (ADDR_W < 4 || ADDR_W > 8) begin : g_bad_addr
         $error("ptick_timer: ADDR_W must be 4..8");
      end
      if (CNT_W < 2 || CNT_W > CTRL_FLAG_BIT + 8) begin : g_bad_cnt
         $error("ptick_timer: CNT_W out of range");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic              flag_q;
   logic              irq_q;
   logic [CNT_W-1:0]  reload_q;
   logic [CNT_W-1:0]  count;
   logic              running;
   logic              expire;
   logic              qual;
   logic [BUS_W-1:0]  calib;
   reg_sel_e          sel;
   logic              acc;
   logic              wr;
   logic              rd;
   logic              wr_ctrl;
   logic              rd_ctrl;
   logic              wr_count;
   logic              start;
   logic              stop;

   logic unused_wdata;
   assign unused_wdata = ^req_wdata;

   always_comb begin
      if (req_addr == OFF_CTRL[ADDR_W-1:0]) begin
         sel = SEL_CTRL;
      end else if (req_addr == OFF_RELOAD[ADDR_W-1:0]) begin
         sel = SEL_RELOAD;
      end else if (req_addr == OFF_COUNT[ADDR_W-1:0]) begin
         sel = SEL_COUNT;
      end else if (req_addr == OFF_CALIB[ADDR_W-1:0]) begin
         sel = SEL_CALIB;
      end else begin
         sel = SEL_NONE;
      end
   end

   assign acc      = req_valid & ~req_user;
   assign wr       = acc & req_write;
   assign rd       = acc & ~req_write;
   assign wr_ctrl  = wr & (sel == SEL_CTRL);
   assign rd_ctrl  = rd & (sel == SEL_CTRL);
   assign wr_count = wr & (sel == SEL_COUNT);
   assign start    = wr_ctrl & req_wdata[CTRL_EN_BIT] & ~ctrl_q.en;
   assign stop     = wr_ctrl & ~req_wdata[CTRL_EN_BIT] & ctrl_q.en;
   assign rsp_err  = req_valid & req_user;
   assign irq_pulse = irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '{cs: CS_FORCE, ie: 1'b0, en: 1'b0};
         flag_q    <= 1'b0;
         irq_q     <= 1'b0;
         reload_q  <= '0;
      end else begin
         irq_q <= expire & ctrl_q.ie;
         if (wr_ctrl) begin
            ctrl_q.en <= req_wdata[CTRL_EN_BIT];
            ctrl_q.ie <= req_wdata[CTRL_IE_BIT];
            ctrl_q.cs <= req_wdata[CTRL_CS_BIT] | CS_FORCE;
         end
         if (wr && sel == SEL_RELOAD) begin
            reload_q <= req_wdata[CNT_W-1:0];
         end
         if (expire) begin
            flag_q <= 1'b1;
         end else if (rd_ctrl || wr_count) begin
            flag_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rsp_rdata = '0;
      if (rd) begin
         unique case (sel)
            SEL_CTRL: begin
               rsp_rdata[CTRL_EN_BIT]   = ctrl_q.en;
               rsp_rdata[CTRL_IE_BIT]   = ctrl_q.ie;
               rsp_rdata[CTRL_CS_BIT]   = ctrl_q.cs;
               rsp_rdata[CTRL_FLAG_BIT] = flag_q;
            end
            SEL_RELOAD: rsp_rdata[CNT_W-1:0] = reload_q;
            SEL_COUNT:  rsp_rdata[CNT_W-1:0] = count;
            SEL_CALIB:  rsp_rdata = calib;
            default:    rsp_rdata = '0;
         endcase
      end
   end

   ptick_qual #(
      .HAS_REF(HAS_REF)
   ) i_qual (
      .clksrc  (ctrl_q.cs),
      .ref_tick(ref_tick),
      .qual    (qual)
   );

   ptick_counter #(
      .CNT_W(CNT_W)
   ) i_counter (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (ctrl_q.en),
      .qual   (qual),
      .start  (start),
      .stop   (stop),
      .clear  (wr_count),
      .reload (reload_q),
      .count  (count),
      .running(running),
      .expire (expire)
   );

   ptick_calib #(
      .CNT_W     (CNT_W),
      .HAS_REF   (HAS_REF),
      .TENMS_CNT (TENMS_CNT),
      .TENMS_SKEW(TENMS_SKEW)
   ) i_calib (
      .calib(calib)
   );

   // R5
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse);

   // R5
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> flag_q);

   // R8
   user_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user) |-> (rsp_err && rsp_rdata == '0));

   // R3
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ctrl && !expire) |=> !flag_q);

   generate
      if (!HAS_REF) begin : g_cs_chk
         // R9
         cs_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ctrl_q.cs);
      end
   endgenerate

endmodule

// File: tb/test_ptick_timer.sv
module test_ptick_timer;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      int          dut;
      logic [31:0] data;
      logic        err;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_tick = 1'b0;
   logic        b_valid = 1'b0;
   logic        b_write = 1'b0;
   logic        b_user = 1'b0;
   logic [4:0]  b_addr = '0;
   logic [31:0] b_wdata = '0;
   int          b_sel = 0;

   logic [31:0] rdata_a, rdata_b;
   logic        err_a, err_b, irq_a, irq_b;

   int   n_checks = 0;
   int   n_errors = 0;
   int   irq_cnt  = 0;
   bit   done     = 1'b0;
   item_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ptick_timer #(
      .ADDR_W(5), .CNT_W(24), .HAS_REF(1'b1), .TENMS_CNT(1000), .TENMS_SKEW(1'b1)
   ) i_ptick_timer (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
      .req_valid(b_valid && b_sel == 0), .req_write(b_write), .req_user(b_user),
      .req_addr(b_addr), .req_wdata(b_wdata),
      .rsp_rdata(rdata_a), .rsp_err(err_a), .irq_pulse(irq_a)
   );

   ptick_timer #(
      .ADDR_W(5), .CNT_W(24), .HAS_REF(1'b0), .TENMS_CNT(1000), .TENMS_SKEW(1'b0)
   ) i_ptick_timer_noref (
      .clk(clk), .rst_n(rst_n), .ref_tick(1'b0),
      .req_valid(b_valid && b_sel == 1), .req_write(b_write), .req_user(b_user),
      .req_addr(b_addr), .req_wdata(b_wdata),
      .rsp_rdata(rdata_b), .rsp_err(err_b), .irq_pulse(irq_b)
   );

   // Monitor: pops one expected item per request and compares
   always @(negedge clk) begin
      #(CLK_PERIOD/4);
      if (b_valid) begin
         item_t it;
         logic [31:0] got_d;
         logic        got_e;
         n_checks++;
         if (q.size() == 0) begin
            n_errors++;
            $display("FAIL %s: monitor saw a request with no expected item", "scoreboard");
         end else begin
            it = q.pop_front();
            got_d = (it.dut == 0) ? rdata_a : rdata_b;
            got_e = (it.dut == 0) ? err_a : err_b;
            if (got_d !== it.data || got_e !== it.err) begin
               n_errors++;
               $display("FAIL %s: data=%h err=%b expected data=%h err=%b",
                        it.tag, got_d, got_e, it.data, it.err);
            end
         end
      end
   end

   always @(negedge clk) if (irq_a === 1'b1) irq_cnt++;

   task automatic op(input int d, input logic w, input logic [4:0] a,
                     input logic [31:0] v, input logic u,
                     input logic [31:0] exp, input string tag);
      item_t it;
      it.dut = d; it.data = exp; it.err = u; it.tag = tag;
      q.push_back(it);
      b_sel = d; b_valid = 1'b1; b_write = w; b_addr = a; b_wdata = v; b_user = u;
      @(negedge clk);
      b_valid = 1'b0; b_write = 1'b0; b_user = 1'b0;
   endtask

   task automatic rd(input int d, input logic [4:0] a, input logic [31:0] exp, input string tag);
      op(d, 1'b0, a, 32'h0, 1'b0, exp, tag);
   endtask

   task automatic wr(input int d, input logic [4:0] a, input logic [31:0] v, input string tag);
      op(d, 1'b1, a, v, 1'b0, 32'h0, tag);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ref(input int n);
      for (int i = 0; i < n; i++) begin
         ref_tick = 1'b1;
         @(negedge clk);
         ref_tick = 1'b0;
      end
   endtask

   task automatic check_irq(input int exp, input string tag);
      n_checks++;
      if (irq_cnt != exp) begin
         n_errors++;
         $display("FAIL %s: irq pulses=%0d expected=%0d", tag, irq_cnt, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state, R10 calibration
      rd(0, 5'h00, 32'h0, "R11 ctrl after reset");
      rd(0, 5'h04, 32'h0, "R11 reload after reset");
      rd(0, 5'h08, 32'h0, "R11 count after reset");
      rd(0, 5'h0C, 32'h4000_03E7, "R10 calibration with reference");

      // R1 unused offset
      rd(0, 5'h14, 32'h0, "R1 unused offset read");
      wr(0, 5'h14, 32'hFFFF_FFFF, "R1 unused offset write");
      rd(0, 5'h00, 32'h0, "R1 ctrl untouched");
      rd(0, 5'h04, 32'h0, "R1 reload untouched");

      // R4 reload width
      wr(0, 5'h04, 32'hFF00_0005, "R4 reload write");
      rd(0, 5'h04, 32'h0000_0005, "R4 reload readback");

      // R2 only bits 2:0 stored
      wr(0, 5'h00, 32'hFFFF_FFF8, "R2 ctrl upper write");
      rd(0, 5'h00, 32'h0, "R2 ctrl upper ignored");

      // R13 reference strobe qualifies ticks
      wr(0, 5'h00, 32'h1, "R13 enable on reference");
      idle(5);
      rd(0, 5'h08, 32'h0, "R13 no strobe no count");
      pulse_ref(1);
      rd(0, 5'h08, 32'h5, "R5 load from zero");
      pulse_ref(4);
      rd(0, 5'h08, 32'h1, "R13 strobe count");
      pulse_ref(1);
      rd(0, 5'h00, 32'h0001_0001, "R5 flag set at expiry");
      rd(0, 5'h00, 32'h0000_0001, "R3 flag cleared by read");
      check_irq(0, "R5 no irq when disabled");

      // R12 same enable rewrite keeps counting
      wr(0, 5'h00, 32'h3, "R12 rewrite enable");
      pulse_ref(1);
      rd(0, 5'h08, 32'h5, "R12 still counting");

      // R13 switch to core clock; R5 interrupt
      wr(0, 5'h00, 32'h7, "R13 core clock");
      idle(7);
      wr(0, 5'h00, 32'h6, "R12 disable");
      rd(0, 5'h08, 32'h3, "R12 frozen value");
      idle(3);
      rd(0, 5'h08, 32'h3, "R12 stays frozen");
      check_irq(1, "R5 one irq pulse");

      // R7 count write clears count and flag
      wr(0, 5'h08, 32'h0000_0123, "R7 count write");
      rd(0, 5'h00, 32'h6, "R7 flag cleared");
      rd(0, 5'h08, 32'h0, "R7 count zeroed");
      wr(0, 5'h00, 32'h7, "R12 start");
      wr(0, 5'h00, 32'h6, "R12 stop");
      rd(0, 5'h08, 32'h5, "R12 started from zero, R7 reload");

      // R6 zero reload halts
      wr(0, 5'h04, 32'h0, "R6 reload zero");
      wr(0, 5'h00, 32'h7, "R6 start");
      idle(8);
      rd(0, 5'h08, 32'h0, "R6 halted at zero");
      rd(0, 5'h00, 32'h0001_0007, "R6 enable stays set");
      check_irq(2, "R6 expiry irq");
      wr(0, 5'h04, 32'h3, "R6 reload nonzero");
      idle(4);
      rd(0, 5'h08, 32'h0, "R6 stays halted");
      wr(0, 5'h00, 32'h7, "R12 same enable while halted");
      idle(2);
      rd(0, 5'h08, 32'h0, "R12 halted unchanged");

      // R7 count write overrides tick, then reload
      wr(0, 5'h00, 32'h6, "R7 stop");
      wr(0, 5'h00, 32'h7, "R7 start");
      wr(0, 5'h08, 32'h0, "R7 clear over tick");
      rd(0, 5'h08, 32'h0, "R7 cleared");
      rd(0, 5'h08, 32'h3, "R7 reload after clear");
      wr(0, 5'h00, 32'h6, "R7 stop again");
      rd(0, 5'h08, 32'h1, "R7 frozen");
      check_irq(2, "R7 no extra irq");

      // R8 user access
      op(0, 1'b0, 5'h00, 32'h0, 1'b1, 32'h0, "R8 user read");
      op(0, 1'b1, 5'h04, 32'hFFFF, 1'b1, 32'h0, "R8 user write reload");
      rd(0, 5'h04, 32'h3, "R8 reload unchanged");
      op(0, 1'b1, 5'h08, 32'h0, 1'b1, 32'h0, "R8 user write count");
      rd(0, 5'h08, 32'h1, "R8 count unchanged");
      op(0, 1'b1, 5'h00, 32'h1, 1'b1, 32'h0, "R8 user write ctrl");
      rd(0, 5'h00, 32'h6, "R8 ctrl unchanged");

      // R9 / R10 / R11 without reference
      rd(1, 5'h00, 32'h4, "R11 R9 noref ctrl after reset");
      wr(1, 5'h00, 32'h0, "R9 clear clksrc attempt");
      rd(1, 5'h00, 32'h4, "R9 clksrc forced");
      rd(1, 5'h0C, 32'h8000_0000, "R10 calibration without reference");
      wr(1, 5'h04, 32'h2, "R9 reload");
      wr(1, 5'h00, 32'h1, "R9 enable with source 0 written");
      idle(3);
      rd(1, 5'h00, 32'h0001_0005, "R9 counts core clock");

      idle(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule